// File: doc/BRIEF.md
# Interrupt vector acknowledge unit

This block holds the pending hardware interrupt requests of a processor and answers its interrupt acknowledge cycles. Devices raise requests by pulsing bits of a flat set bus; each of the hardware levels keeps one pending word with one bit per source. When the processor acknowledges a level, the unit picks one pending source at that level, clears it, and returns the vector for it one clock later with a valid pulse.

Every source has a configured default vector and a configured forced-bits value, both supplied as static configuration buses. A device that supplies its vector dynamically drives the override input during the acknowledge. The returned vector is confined to a longword-aligned field in bits 8:2, and only forced bits may appear outside that field. A separate memory-error flag is acknowledged on its own level and always yields a fixed vector. Illegal levels raise an error pulse instead of a vector.

Top module: `vec_ack_unit`

## Requirements
- R1: On an acknowledge of a hardware level, the lowest-numbered pending source of that level is selected and only its pending bit is cleared. Hardware levels 20 to 23 (ack_lvl_i) map to banks 0 to 3; source s of bank b is bit b*32+s of req_set_i, pend_o and the configuration buses (16-bit slices for the vector buses).
- R2: The vector for the selected source is (src | force) & (force | 0x1FC), where src is ovr_vec_i when ovr_valid_i is high and the source's default vector otherwise, and force is the source's forced-bits value.
- R3: An acknowledge of a hardware level with no pending source returns vector 0 with a valid pulse and changes no pending bit.
- R4: An acknowledge of level 29 returns vector 0x60 with a valid pulse and clears the memory-error flag; memerr_set_i sets that flag.
- R5: An acknowledge of a level above 23 other than 29 produces a one-cycle lvl_err_o pulse, no valid pulse, and no change to any pending bit or to the memory-error flag.
- R6: A bus_reset_i cycle clears all pending bits in every bank and ignores sets in that cycle; the memory-error flag is kept. After rst_ni all pending bits, the flag and all outputs are zero.
- R7: A set and an acknowledge clear of the same bit in the same cycle leave the bit pending.
- R8: vec_o, vec_valid_o and lvl_err_o are registered: they respond on the clock edge that samples ack_i, last one cycle, and vec_o is 0 whenever vec_valid_o is low.
- R9: An acknowledge of a level below 20 returns vector 0 with a valid pulse, no error, and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | Synchronous clear of all pending requests |
| req_set_i | input | 128 | Request set pulses, bank b source s at bit b*32+s |
| dflt_vec_i | input | 2048 | Default vector per source, 16 bits each |
| force_vec_i | input | 2048 | Forced-bits value per source, 16 bits each |
| ovr_valid_i | input | 1 | Dynamic vector supplied with this acknowledge |
| ovr_vec_i | input | 16 | Dynamic vector value |
| memerr_set_i | input | 1 | Raise the memory-error flag |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | 5 | Acknowledged level |
| vec_o | output | 16 | Returned vector |
| vec_valid_o | output | 1 | Vector valid pulse |
| lvl_err_o | output | 1 | Illegal level pulse |
| pend_o | output | 128 | Pending request bits |
| memerr_pend_o | output | 1 | Memory-error flag |

## Verification
The bench builds the unit with its defaults: four banks of 32 sources, 16-bit vectors, hardware levels 20 to 23 and the memory-error level 29. With full 32-bit banks the picker is driven up to source 31, and with 16-bit vectors the forced bits at 15 and 1:0 can be seen surviving the mask while default-vector bits at 13:12 and 1:0 are stripped. A long random phase with sparse sets on all banks, random overrides and occasional bus resets makes set-versus-clear collisions on the same bit occur alongside the directed cases.

// File: rtl/vack_pkg.sv
package vack_pkg;
  typedef enum logic [2:0] {
    ACK_NONE,
    ACK_HW,
    ACK_MEM,
    ACK_LOW,
    ACK_BAD
  } ack_kind_e;
endpackage

// File: rtl/vack_prio_pick.sv
module vack_prio_pick #(
  parameter int SRC_N = 32,
  parameter int SW    = 5
) (
  input  logic [SRC_N-1:0] req_i,
  output logic             any_o,
  output logic [SW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = SW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/vack_pend_bank.sv
module vack_pend_bank #(
  parameter int NUM_LVL = 4,
  parameter int SRC_N   = 32,
  parameter int LI_W    = 2,
  parameter int SW      = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_reset_i,
  input  logic [NUM_LVL*SRC_N-1:0] set_i,
  input  logic                     clr_en_i,
  input  logic [LI_W-1:0]          clr_lvl_i,
  input  logic [SW-1:0]            clr_src_i,
  output logic [NUM_LVL*SRC_N-1:0] pend_o
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [SRC_N-1:0] clr_mask, q;
    assign clr_mask = (clr_en_i && clr_lvl_i == LI_W'(l)) ? (SRC_N'(1) << clr_src_i) : '0;
    // set is applied after clear so a colliding set survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (bus_reset_i) q <= '0;
      else                  q <= (q & ~clr_mask) | set_i[l*SRC_N +: SRC_N];
    end
    assign pend_o[l*SRC_N +: SRC_N] = q;
  end
endmodule

// File: rtl/vack_vec_form.sv
module vack_vec_form #(
  parameter int NUM_LVL  = 4,
  parameter int SRC_N    = 32,
  parameter int VEC_W    = 16,
  parameter int LI_W     = 2,
  parameter int SW       = 5,
  parameter int VEC_KEEP = 'h1FC
) (
  input  logic [NUM_LVL*SRC_N*VEC_W-1:0] dflt_i,
  input  logic [NUM_LVL*SRC_N*VEC_W-1:0] force_i,
  input  logic [LI_W-1:0]                lvl_i,
  input  logic [SW-1:0]                  src_i,
  input  logic                           ovr_valid_i,
  input  logic [VEC_W-1:0]               ovr_vec_i,
  output logic [VEC_W-1:0]               vec_o
);
  localparam int SEL_W = LI_W + SW;
  localparam logic [VEC_W-1:0] KEEP_L = VEC_W'(VEC_KEEP);

  logic [SEL_W-1:0] sel;
  logic [VEC_W-1:0] base, frc;

  assign sel   = {lvl_i, src_i};
  assign base  = ovr_valid_i ? ovr_vec_i : dflt_i[sel*VEC_W +: VEC_W];
  assign frc   = force_i[sel*VEC_W +: VEC_W];
  assign vec_o = (base | frc) & (frc | KEEP_L);
endmodule

// File: rtl/vec_ack_unit_chk.sv
module vec_ack_unit_chk #(
  parameter int NUM_LVL    = 4,
  parameter int SRC_N      = 32,
  parameter int VEC_W      = 16,
  parameter int LVL_W      = 5,
  parameter int HW_LVL_MIN = 20,
  parameter int MEM_LVL    = 29,
  parameter int MEM_VEC    = 'h60
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           bus_reset_i,
  input logic [NUM_LVL*SRC_N-1:0]       req_set_i,
  input logic                           memerr_set_i,
  input logic                           ack_i,
  input logic [LVL_W-1:0]               ack_lvl_i,
  input logic [VEC_W-1:0]               vec_o,
  input logic                           vec_valid_o,
  input logic                           lvl_err_o,
  input logic [NUM_LVL*SRC_N-1:0]       pend_o,
  input logic                           memerr_pend_o
);
  localparam logic [LVL_W-1:0] HW_MAX_L = LVL_W'(HW_LVL_MIN + NUM_LVL - 1);
  localparam logic [LVL_W-1:0] MEM_L    = LVL_W'(MEM_LVL);

  logic bad_lvl;
  assign bad_lvl = ack_i && ack_lvl_i > HW_MAX_L && ack_lvl_i != MEM_L;

  assert_set_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_reset_i |=> ((pend_o & $past(req_set_i)) == $past(req_set_i)));

  assert_bus_reset_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (pend_o == '0));

  assert_bad_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_lvl && !bus_reset_i && req_set_i == '0 && !memerr_set_i)
      |=> (lvl_err_o && !vec_valid_o && $stable(pend_o) && $stable(memerr_pend_o)));

  assert_memerr_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_lvl_i == MEM_L && !memerr_set_i)
      |=> (vec_valid_o && vec_o == VEC_W'(MEM_VEC) && !memerr_pend_o));

  assert_valid_follows_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o || lvl_err_o) |-> $past(ack_i));

  assert_valid_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_valid_o && lvl_err_o));

  assert_vec_zero_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == '0));
endmodule

// File: rtl/vec_ack_unit.sv
module vec_ack_unit
  import vack_pkg::*;
#(
  parameter int NUM_LVL    = 4,
  parameter int SRC_N      = 32,
  parameter int VEC_W      = 16,
  parameter int LVL_W      = 5,
  parameter int HW_LVL_MIN = 20,
  parameter int MEM_LVL    = 29,
  parameter int MEM_VEC    = 'h60,
  parameter int VEC_KEEP   = 'h1FC
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_reset_i,
  input  logic [NUM_LVL*SRC_N-1:0]       req_set_i,
  input  logic [NUM_LVL*SRC_N*VEC_W-1:0] dflt_vec_i,
  input  logic [NUM_LVL*SRC_N*VEC_W-1:0] force_vec_i,
  input  logic                           ovr_valid_i,
  input  logic [VEC_W-1:0]               ovr_vec_i,
  input  logic                           memerr_set_i,
  input  logic                           ack_i,
  input  logic [LVL_W-1:0]               ack_lvl_i,
  output logic [VEC_W-1:0]               vec_o,
  output logic                           vec_valid_o,
  output logic                           lvl_err_o,
  output logic [NUM_LVL*SRC_N-1:0]       pend_o,
  output logic                           memerr_pend_o
);
  localparam int LI_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam int SW   = (SRC_N > 1) ? $clog2(SRC_N) : 1;
  localparam logic [LVL_W-1:0] HW_MIN_L = LVL_W'(HW_LVL_MIN);
  localparam logic [LVL_W-1:0] HW_MAX_L = LVL_W'(HW_LVL_MIN + NUM_LVL - 1);
  localparam logic [LVL_W-1:0] MEM_L    = LVL_W'(MEM_LVL);

  ack_kind_e        kind;
  logic [LI_W-1:0]  lvl_idx;
  logic [SRC_N-1:0] lvl_req;
  logic             any_req;
  logic [SW-1:0]    src_idx;
  logic [VEC_W-1:0] formed_vec;
  logic             clr_en;
  logic [VEC_W-1:0] vec_q;
  logic             valid_q, err_q, memerr_q;

  always_comb begin
    kind    = ACK_NONE;
    lvl_idx = '0;
    if (ack_i) begin
      if (ack_lvl_i == MEM_L)         kind = ACK_MEM;
      else if (ack_lvl_i > HW_MAX_L)  kind = ACK_BAD;
      else if (ack_lvl_i < HW_MIN_L)  kind = ACK_LOW;
      else begin
        kind = ACK_HW;
        for (int l = 0; l < NUM_LVL; l++) begin
          if (ack_lvl_i == LVL_W'(HW_LVL_MIN + l)) lvl_idx = LI_W'(l);
        end
      end
    end
  end

  assign lvl_req = pend_o[lvl_idx*SRC_N +: SRC_N];
  assign clr_en  = (kind == ACK_HW) && any_req;

  vack_prio_pick #(.SRC_N(SRC_N), .SW(SW)) u_pick (
    .req_i (lvl_req),
    .any_o (any_req),
    .idx_o (src_idx)
  );

  vack_pend_bank #(.NUM_LVL(NUM_LVL), .SRC_N(SRC_N), .LI_W(LI_W), .SW(SW)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .set_i       (req_set_i),
    .clr_en_i    (clr_en),
    .clr_lvl_i   (lvl_idx),
    .clr_src_i   (src_idx),
    .pend_o      (pend_o)
  );

  vack_vec_form #(
    .NUM_LVL(NUM_LVL), .SRC_N(SRC_N), .VEC_W(VEC_W),
    .LI_W(LI_W), .SW(SW), .VEC_KEEP(VEC_KEEP)
  ) u_form (
    .dflt_i      (dflt_vec_i),
    .force_i     (force_vec_i),
    .lvl_i       (lvl_idx),
    .src_i       (src_idx),
    .ovr_valid_i (ovr_valid_i),
    .ovr_vec_i   (ovr_vec_i),
    .vec_o       (formed_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      vec_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      case (kind)
        ACK_HW: begin
          valid_q <= 1'b1;
          vec_q   <= any_req ? formed_vec : '0;
        end
        ACK_MEM: begin
          valid_q <= 1'b1;
          vec_q   <= VEC_W'(MEM_VEC);
        end
        ACK_LOW: valid_q <= 1'b1;
        ACK_BAD: err_q   <= 1'b1;
        default: ;
      endcase
    end
  end

  // bus reset leaves the memory-error flag alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) memerr_q <= 1'b0;
    else         memerr_q <= memerr_set_i | (memerr_q & (kind != ACK_MEM));
  end

  assign vec_o         = vec_q;
  assign vec_valid_o   = valid_q;
  assign lvl_err_o     = err_q;
  assign memerr_pend_o = memerr_q;
endmodule

bind vec_ack_unit vec_ack_unit_chk #(
  .NUM_LVL(NUM_LVL), .SRC_N(SRC_N), .VEC_W(VEC_W), .LVL_W(LVL_W),
  .HW_LVL_MIN(HW_LVL_MIN), .MEM_LVL(MEM_LVL), .MEM_VEC(MEM_VEC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_reset_i   (bus_reset_i),
  .req_set_i     (req_set_i),
  .memerr_set_i  (memerr_set_i),
  .ack_i         (ack_i),
  .ack_lvl_i     (ack_lvl_i),
  .vec_o         (vec_o),
  .vec_valid_o   (vec_valid_o),
  .lvl_err_o     (lvl_err_o),
  .pend_o        (pend_o),
  .memerr_pend_o (memerr_pend_o)
);

// File: tb/vec_ack_unit_tb.sv
module vec_ack_unit_tb;
  localparam int NL = 4;
  localparam int NS = 32;
  localparam int VW = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bus_reset_i = 1'b0;
  logic [NL*NS-1:0] req_set_i = '0;
  logic [NL*NS*VW-1:0] dflt_vec_i, force_vec_i;
  logic             ovr_valid_i = 1'b0;
  logic [VW-1:0]    ovr_vec_i = '0;
  logic             memerr_set_i = 1'b0;
  logic             ack_i = 1'b0;
  logic [4:0]       ack_lvl_i = '0;
  logic [VW-1:0]    vec_o;
  logic             vec_valid_o, lvl_err_o, memerr_pend_o;
  logic [NL*NS-1:0] pend_o;

  int checks = 0;
  int failures = 0;
  string tag = "R6";
  bit done = 1'b0;

  logic [31:0] m_pend [NL];
  bit          m_mem;
  logic [15:0] e_vec;
  bit          e_valid, e_err;

  always #5 clk = ~clk;

  vec_ack_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i), .req_set_i(req_set_i),
    .dflt_vec_i(dflt_vec_i), .force_vec_i(force_vec_i), .ovr_valid_i(ovr_valid_i),
    .ovr_vec_i(ovr_vec_i), .memerr_set_i(memerr_set_i), .ack_i(ack_i), .ack_lvl_i(ack_lvl_i),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o), .lvl_err_o(lvl_err_o), .pend_o(pend_o),
    .memerr_pend_o(memerr_pend_o)
  );

  function automatic logic [15:0] f_dflt(int l, int s);
    return 16'h3000 | 16'((l*32 + s) << 2) | 16'(s % 4);
  endfunction

  function automatic logic [15:0] f_force(int s);
    if (s % 7 == 3) return 16'h8001;
    if (s == 30)    return 16'h0002;
    return 16'h0000;
  endfunction

  initial begin
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < NS; s++) begin
        dflt_vec_i[(l*NS+s)*VW +: VW]  = f_dflt(l, s);
        force_vec_i[(l*NS+s)*VW +: VW] = f_force(s);
      end
  end

  task automatic model();
    logic [31:0] clr [NL];
    bit mem_clr = 0;
    int lv;
    for (int l = 0; l < NL; l++) clr[l] = '0;
    e_vec = '0; e_valid = 0; e_err = 0;
    if (ack_i) begin
      lv = int'(ack_lvl_i);
      if (lv == 29) begin e_vec = 16'h0060; e_valid = 1; mem_clr = 1; end
      else if (lv > 23) e_err = 1;
      else if (lv < 20) e_valid = 1;
      else begin
        int b = lv - 20;
        e_valid = 1;
        for (int s = 0; s < NS; s++) begin
          if (m_pend[b][s]) begin
            logic [15:0] src, fb;
            src = ovr_valid_i ? ovr_vec_i : f_dflt(b, s);
            fb  = f_force(s);
            e_vec = (src | fb) & (fb | 16'h01FC);
            clr[b][s] = 1'b1;
            break;
          end
        end
      end
    end
    m_mem = memerr_set_i || (m_mem && !mem_clr);
    for (int l = 0; l < NL; l++)
      m_pend[l] = bus_reset_i ? 32'h0 : ((m_pend[l] & ~clr[l]) | req_set_i[l*NS +: NS]);
  endtask

  task automatic chk(bit ok, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NL*NS-1:0] ep;
    for (int l = 0; l < NL; l++) ep[l*NS +: NS] = m_pend[l];
    chk(vec_o === e_vec, "vec_o", 128'(vec_o), 128'(e_vec));
    chk(vec_valid_o === e_valid, "vec_valid_o", 128'(vec_valid_o), 128'(e_valid));
    chk(lvl_err_o === e_err, "lvl_err_o", 128'(lvl_err_o), 128'(e_err));
    chk(pend_o === ep, "pend_o", 128'(pend_o), 128'(ep));
    chk(memerr_pend_o === m_mem, "memerr_pend_o", 128'(memerr_pend_o), 128'(m_mem));
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    req_set_i = '0; ack_i = 0; ovr_valid_i = 0; memerr_set_i = 0; bus_reset_i = 0;
  endtask

  task automatic ack(int lv);
    ack_i = 1; ack_lvl_i = 5'(lv);
  endtask

  function automatic int bit_of(int lv, int s);
    return (lv - 20) * NS + s;
  endfunction

  initial begin
    for (int l = 0; l < NL; l++) m_pend[l] = '0;
    m_mem = 0; e_vec = '0; e_valid = 0; e_err = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tag = "R6";  // reset state
    compare();

    // R1, R2: lowest pending source first, one bit cleared per ack
    tag = "R1";
    req_set_i[bit_of(20, 5)] = 1; req_set_i[bit_of(20, 9)] = 1; req_set_i[bit_of(20, 31)] = 1;
    req_set_i[bit_of(20, 3)] = 1;
    step();
    for (int k = 0; k < 4; k++) begin ack(20); step(); end
    step();
    tag = "R3";  // empty level returns zero
    ack(20); step(); step();

    tag = "R2";  // override masked to the aligned field, forced bits kept
    req_set_i[bit_of(22, 3)] = 1; req_set_i[bit_of(22, 4)] = 1; req_set_i[bit_of(21, 30)] = 1;
    step();
    ack(22); ovr_valid_i = 1; ovr_vec_i = 16'hFFFF; step();
    ack(22); ovr_valid_i = 1; ovr_vec_i = 16'h7FFF; step();
    ack(21); step(); step();

    tag = "R4";
    memerr_set_i = 1; step();
    ack(29); step(); step();
    ack(29); step();

    tag = "R5";
    req_set_i[bit_of(23, 0)] = 1; memerr_set_i = 1; step();
    ack(24); step();
    ack(31); step(); step();

    tag = "R9";
    ack(7); step();
    ack(0); step();

    tag = "R7";  // set collides with the clear of the same bit
    ack(23); req_set_i[bit_of(23, 0)] = 1; step();
    ack(23); step(); step();

    tag = "R6";
    for (int l = 0; l < NL; l++) req_set_i[l*NS +: NS] = 32'h8421_1248;
    step();
    bus_reset_i = 1; req_set_i[5] = 1; step(); step();

    tag = "R8";  // back-to-back acks
    req_set_i[bit_of(21, 2)] = 1; req_set_i[bit_of(21, 6)] = 1; step();
    ack(21); step();
    ack(21); step();
    ack(25); step(); step();

    tag = "R1";  // random mix
    for (int c = 0; c < 400; c++) begin
      for (int l = 0; l < NL; l++) req_set_i[l*NS +: NS] = $urandom & $urandom & $urandom;
      if ($urandom % 3 != 0) begin
        case ($urandom % 8)
          0, 1, 2, 3: ack(20 + int'($urandom % 4));
          4: ack(29);
          5: ack(24);
          6: ack(31);
          default: ack(7);
        endcase
      end
      ovr_valid_i  = ($urandom % 4) == 0;
      ovr_vec_i    = 16'($urandom);
      memerr_set_i = ($urandom % 6) == 0;
      bus_reset_i  = ($urandom % 50) == 0;
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule